// File: doc/BRIEF.md
# Timer Clear Event Qualifier

This block sits in front of a limit timer's counter and decides, cycle by cycle, whether that counter is to be cleared at the coming timer tick. It takes six external activity signals, runs them through a synchroniser, and picks one of them with a 3-bit select. Activity on the picked signal becomes a clear request according to two independent polarity channels. The high channel reacts to a high level or a rising edge. The low channel reacts to a low level or a falling edge. Each channel has its own enable and its own edge-or-level choice.

The output `clr_o` is a one-cycle request that is valid only in cycles where the timer clock enable `tick_i` is high. The timer clears its counter on the rising clock edge that ends such a cycle. An edge that arrives between ticks is held until the next tick, so a slow prescaled timer still sees short events. A counter write from software in the same cycle wins over any request and discards what was held.

Top module: `lt_clr_qualifier`

## Requirements
- R1: `sel_i` values 0 to 5 pick `src_i[sel_i]`. Values 6 and 7 pick nothing, and activity on an unselected input never produces a clear.
- R2: With `rise_en_i`=1 and `rise_edge_i`=0, every tick cycle in which the synchronised selected source is 1 asserts `clr_o`. With `rise_en_i`=0, the high channel never asserts it.
- R3: With `fall_en_i`=1 and `fall_edge_i`=0, every tick cycle in which the synchronised selected source is 0 asserts `clr_o`. With `fall_en_i`=0, the low channel never asserts it.
- R4: With `rise_en_i`=1 and `rise_edge_i`=1, each 0-to-1 transition of the selected source gives exactly one `clr_o` cycle, and a steady high gives no more.
- R5: With `fall_en_i`=1 and `fall_edge_i`=1, each 1-to-0 transition gives exactly one `clr_o` cycle, and a steady low gives no more.
- R6: An edge detected while `tick_i`=0 is held and asserts `clr_o` in the next cycle with `tick_i`=1. It is then consumed.
- R7: `clr_o` is 0 in every cycle with `tick_i`=0.
- R8: `cnt_wr_i`=1 forces `clr_o` to 0 in that cycle and discards any held edge, so that edge gives no clear later.
- R9: A change of `sel_i` does not create an edge, even when the old and new sources differ in level.
- R10: A source change set up before clock edge k reaches the synchronised level after edge k+1. In edge mode it asserts `clr_o` (with `tick_i`=1) in the cycle between edges k+1 and k+2.
- R11: While `rst_ni` is low, the synchroniser, edge history and held edges are cleared, and `clr_o` stays 0 in rising-level mode even with all sources high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 6 | Asynchronous candidate clear sources |
| sel_i | input | 3 | Source select; 6 and 7 select none |
| rise_en_i | input | 1 | Enable the high/rising channel |
| fall_en_i | input | 1 | Enable the low/falling channel |
| rise_edge_i | input | 1 | High channel is edge sensitive (0 = level) |
| fall_edge_i | input | 1 | Low channel is edge sensitive (0 = level) |
| tick_i | input | 1 | Timer clock enable |
| cnt_wr_i | input | 1 | Software write to the timer counter |
| clr_o | output | 1 | Clear the counter at the end of this cycle |

## Verification
A stale edge-history register shows up as an extra or a missing `clr_o` exactly two cycles after a source change, or on the cycle of a select change. A held edge that is never cleared shows up on the first tick after a counter write, or as a second pulse after a consumed one. Because every held state drains at the next tick, each fault becomes visible within one tick period of its cause. The sweeps keep `tick_i` high so that timing is exact to the cycle, and directed cases stretch the tick gap to expose held edges.

// File: rtl/lt_clr_pkg.sv
package lt_clr_pkg;
  localparam int DEF_NUM_SRC   = 6;
  localparam int DEF_SYNC_DEPTH = 2;

  typedef struct packed {
    logic en;
    logic edge_mode;
  } pol_cfg_t;
endpackage

// File: rtl/lt_clr_sync.sv
module lt_clr_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lt_clr_edge.sv
module lt_clr_edge #(
  parameter int NUM_SRC = 6,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] sync_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               lvl_hi_o,
  output logic               lvl_lo_o,
  output logic               rise_o,
  output logic               fall_o
);
  logic [SEL_W-1:0] sel_q;
  logic             prev_q;
  logic             cur;
  logic             sel_ok;
  logic             hist_ok;

  always_comb begin
    cur    = 1'b0;
    sel_ok = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (sel_i == SEL_W'(k)) begin
        cur    = sync_i[k];
        sel_ok = 1'b1;
      end
    end
  end

  // history belongs to the old source on a select change
  assign hist_ok  = sel_ok && (sel_i == sel_q);
  assign lvl_hi_o = sel_ok && cur;
  assign lvl_lo_o = sel_ok && !cur;
  assign rise_o   = hist_ok && cur && !prev_q;
  assign fall_o   = hist_ok && !cur && prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      sel_q  <= sel_i;
      prev_q <= cur;
    end
  end
endmodule

// File: rtl/lt_clr_arm.sv
module lt_clr_arm
  import lt_clr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pol_cfg_t cfg_i,
  input  logic     edge_i,
  input  logic     level_i,
  input  logic     tick_i,
  input  logic     wr_i,
  output logic     req_o
);
  logic pend_q;
  logic armed;
  logic want;

  assign armed = cfg_i.en && cfg_i.edge_mode;
  assign want  = cfg_i.edge_mode ? (pend_q || edge_i) : level_i;
  assign req_o = tick_i && !wr_i && cfg_i.en && want;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pend_q <= 1'b0;
    else if (wr_i || tick_i || !armed) pend_q <= 1'b0;
    else if (edge_i)                  pend_q <= 1'b1;
  end
endmodule

// File: rtl/lt_clr_qualifier.sv
module lt_clr_qualifier
  import lt_clr_pkg::*;
#(
  parameter int NUM_SRC    = DEF_NUM_SRC,
  parameter int SYNC_DEPTH = DEF_SYNC_DEPTH,
  localparam int SEL_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               rise_en_i,
  input  logic               fall_en_i,
  input  logic               rise_edge_i,
  input  logic               fall_edge_i,
  input  logic               tick_i,
  input  logic               cnt_wr_i,
  output logic               clr_o
);
  localparam int NUM_POL = 2;

  logic [NUM_SRC-1:0] src_sync;
  logic               lvl_hi, lvl_lo, ev_rise, ev_fall;
  pol_cfg_t           cfg   [NUM_POL];
  logic [NUM_POL-1:0] ev_edge, ev_lvl, req;

  lt_clr_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (src_i),
    .q_o   (src_sync)
  );

  lt_clr_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (src_sync),
    .sel_i   (sel_i),
    .lvl_hi_o(lvl_hi),
    .lvl_lo_o(lvl_lo),
    .rise_o  (ev_rise),
    .fall_o  (ev_fall)
  );

  // channel 0: high/rising, channel 1: low/falling
  assign cfg[0]  = '{en: rise_en_i, edge_mode: rise_edge_i};
  assign cfg[1]  = '{en: fall_en_i, edge_mode: fall_edge_i};
  assign ev_edge = {ev_fall, ev_rise};
  assign ev_lvl  = {lvl_lo, lvl_hi};

  for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
    lt_clr_arm u_arm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg[p]),
      .edge_i (ev_edge[p]),
      .level_i(ev_lvl[p]),
      .tick_i (tick_i),
      .wr_i   (cnt_wr_i),
      .req_o  (req[p])
    );
  end

  assign clr_o = |req;
endmodule

// File: rtl/lt_clr_qualifier_chk.sv
module lt_clr_qualifier_chk #(
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic             rise_en_i,
  input logic             fall_en_i,
  input logic             rise_edge_i,
  input logic             fall_edge_i,
  input logic             tick_i,
  input logic             cnt_wr_i,
  input logic             clr_o
);
  a_r7_tick_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> tick_i);

  a_r8_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |-> !clr_o);

  a_r2_no_enable_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_en_i && !fall_en_i) |-> !clr_o);

  a_r1_none_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(sel_i) >= NUM_SRC && !rise_edge_i && !fall_edge_i) |-> !clr_o);
endmodule

bind lt_clr_qualifier lt_clr_qualifier_chk #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .rise_en_i  (rise_en_i),
  .fall_en_i  (fall_en_i),
  .rise_edge_i(rise_edge_i),
  .fall_edge_i(fall_edge_i),
  .tick_i     (tick_i),
  .cnt_wr_i   (cnt_wr_i),
  .clr_o      (clr_o)
);

// File: tb/lt_clr_qualifier_bench.sv
module lt_clr_qualifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 6;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [NSRC-1:0] src;
  logic [2:0]      sel;
  logic            ren, fen, redg, fedg, tick, wr;
  logic            clr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lt_clr_qualifier u_lt_clr_qualifier (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .sel_i(sel),
    .rise_en_i(ren), .fall_en_i(fen), .rise_edge_i(redg), .fall_edge_i(fedg),
    .tick_i(tick), .cnt_wr_i(wr), .clr_o(clr)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t clr_o=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [2:0] s, input logic re, input logic fe,
                     input logic rg, input logic fg);
    sel = s; ren = re; fen = fe; redg = rg; fedg = fg;
  endtask

  // sample i (1-based) after a source change from o to n, tick held high
  function automatic logic exp_clr(input int i, input logic o, input logic n, input bit valid);
    logic cur, e, r, f;
    if (!valid) return 1'b0;
    cur = (i >= 2) ? n : o;
    e   = (i == 2);
    r   = ren & (redg ? (e & n) : cur);
    f   = fen & (fedg ? (e & ~n) : ~cur);
    return r | f;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; src = '1; tick = 1'b1; wr = 1'b0;
    cfg(3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (3) cyc();
    chk("R11 reset", clr, 1'b0);
    src = '0;
    rst_ni = 1'b1;
    repeat (4) cyc();

    // sweep: select x channel config; R1 R2 R3 R4 R5 R10
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 16; c++) begin
        bit valid;
        logic [NSRC-1:0] pat;
        valid = (s < NSRC);
        pat = valid ? (NSRC'(1) << s) : '1;
        cfg(3'(s), c[0], c[1], c[2], c[3]);
        src = '0;
        repeat (4) cyc();
        src = pat;
        for (int i = 1; i <= 6; i++) begin
          cyc();
          chk("R1 R2 R4 R10 rise phase", clr, exp_clr(i, 1'b0, 1'b1, valid));
        end
        src = '0;
        for (int i = 1; i <= 6; i++) begin
          cyc();
          chk("R1 R3 R5 R10 fall phase", clr, exp_clr(i, 1'b1, 1'b0, valid));
        end
      end
    end

    // R1: unselected input toggles
    cfg(3'd2, 1'b1, 1'b1, 1'b1, 1'b1);
    src = '0;
    repeat (4) cyc();
    src = 6'b010000;
    for (int i = 0; i < 5; i++) begin cyc(); chk("R1 unselected rise", clr, 1'b0); end
    src = '0;
    for (int i = 0; i < 5; i++) begin cyc(); chk("R1 unselected fall", clr, 1'b0); end

    // R6 / R7: edge held across a tick gap
    cfg(3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    repeat (4) cyc();
    tick = 1'b0; src = 6'b000001;
    for (int i = 0; i < 5; i++) begin cyc(); chk("R7 no tick", clr, 1'b0); end
    tick = 1'b1; #1;
    chk("R6 held edge fires", clr, 1'b1);
    cyc();
    chk("R6 consumed", clr, 1'b0);
    chk("R4 steady high", clr, 1'b0);

    // R8: write discards held edge
    src = '0;
    repeat (4) cyc();
    tick = 1'b0; src = 6'b000001;
    repeat (4) cyc();
    tick = 1'b1; wr = 1'b1; #1;
    chk("R8 write blocks", clr, 1'b0);
    cyc();
    wr = 1'b0; #1;
    chk("R8 held edge dropped", clr, 1'b0);

    // R8: write blocks level request
    cfg(3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    wr = 1'b1; #1;
    chk("R8 write blocks level", clr, 1'b0);
    cyc();
    wr = 1'b0; #1;
    chk("R2 level after write", clr, 1'b1);

    // R9: select change between differing levels
    cfg(3'd0, 1'b1, 1'b1, 1'b1, 1'b1);
    src = 6'b000010;
    repeat (4) cyc();
    sel = 3'd1; #1;
    chk("R9 select change", clr, 1'b0);
    for (int i = 0; i < 3; i++) begin cyc(); chk("R9 after change", clr, 1'b0); end
    sel = 3'd0; #1;
    chk("R9 switch back", clr, 1'b0);
    for (int i = 0; i < 3; i++) begin cyc(); chk("R9 after switch back", clr, 1'b0); end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule